// File: doc/BRIEF.md
# Sample-Synchronous Edge Timestamp Meter

This block measures an input signal against a periodic sample strobe, such as an audio frame clock. A fast timestamp counter restarts at every strobe and counts system clock cycles. Each rising edge of the measured signal records the current timestamp, so by the end of a period the block holds the in-period time of the latest edge. It also counts how many edges fell inside that period. Downstream logic can turn these two numbers into a frequency estimate with sub-period resolution, even when the input runs faster than the strobe.

At every strobe, the timestamp and the edge count of the period that just ended are copied into one output register in a single clock edge, and a one-cycle valid pulse marks the new result. An edge that lands right after the boundary therefore belongs to the next period and can never replace the value already reported. Both asynchronous inputs pass through synchronizers and rising-edge detectors. A flag marks periods without any edge, because the timestamp field carries no meaning in that case.

Top module: `sample_edge_meter`

## Requirements
- R1: The timestamp counter restarts at 0 one cycle after a detected strobe and then advances by one per clock. A measured edge driven k cycles (k >= 1) after the strobe, both raw inputs being driven in the same way, is recorded with timestamp k-1.
- R2: When several edges fall in one period, the reported timestamp is that of the last edge. Repeated captures in one period raise no error indication.
- R3: The reported count equals the number of measured rising edges that fell in the period.
- R4: The result is latched at each detected strobe. `res_valid` is high for exactly one clock, 3 clocks after the raw strobe rises (2 synchronizer stages plus the output register). The result fields hold their value between pulses.
- R5: An edge detected in the same cycle as the strobe belongs to the new period, with timestamp 0 and a count of 1. It is absent from the result reported at that strobe.
- R6: An edge arriving shortly after a strobe leaves the result reported at that strobe unchanged.
- R7: The capture and count state clear at every strobe. A period without edges reports a timestamp of 0 and a count of 0.
- R8: `res_none` is 1 exactly when the reported count is 0.
- R9: The edge count saturates at 2^CNT_W-1 and does not wrap.
- R10: If no strobe arrives, the timestamp counter stops at 2^TS_W-1, and later edges record that value.
- R11: Under reset, `res_valid`, `res_stamp`, `res_count` and `res_none` are all 0. The first period is counted from the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_in | input | 1 | Measured signal, asynchronous |
| strobe_in | input | 1 | Sample-rate strobe, asynchronous, rising edge active |
| res_valid | output | 1 | One-cycle pulse when a new result is latched |
| res_stamp | output | TS_W | Timestamp of the last edge in the finished period |
| res_count | output | CNT_W | Saturating edge count of the finished period |
| res_none | output | 1 | Finished period contained no edge |

## Verification
The most likely faults are in the ordering at the boundary. If the snapshot took the capture register after an edge that coincides with the strobe, the reported timestamp would drop to 0, or the count would be off by one, in the very period that ends at that strobe. A missing clear carries the count or timestamp over into the next report, one period later. An off-by-one or a wrap in either counter changes the reported value at the next valid pulse. The sweep moves a single edge across every offset of the period and adds dense, coincident, just-after-boundary and strobe-free periods, so each of these faults shows up in the first result that follows it.

// File: rtl/sem_pkg.sv
package sem_pkg;
   localparam int unsigned MIN_SYNC_STAGES = 2;

   function automatic bit period_fits(int unsigned period, int unsigned width);
      return (width < 31) && (period <= (32'd1 << width));
   endfunction
endpackage

// File: rtl/sem_sync_rise.sv
module sem_sync_rise #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         last  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         last  <= chain[STAGES-1];
      end
   end

   assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/sem_stamp.sv
module sem_stamp #(
   parameter int unsigned TS_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   output logic [TS_W-1:0] stamp
);
   localparam logic [TS_W-1:0] TS_MAX = {TS_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               stamp <= '0;
      else if (restart)         stamp <= '0;
      else if (stamp != TS_MAX) stamp <= stamp + 1'b1;
   end
endmodule

// File: rtl/sem_recorder.sv
module sem_recorder #(
   parameter int unsigned TS_W  = 10,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  stamp,
   input  logic             hit,
   input  logic             close,
   output logic [TS_W-1:0]  cap,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap <= '0;
         cnt <= '0;
      end else if (close) begin
         cap <= '0;
         cnt <= hit ? CNT_ONE : '0;
      end else if (hit) begin
         cap <= stamp;
         if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sem_snapshot.sv
module sem_snapshot #(
   parameter int unsigned TS_W  = 10,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [TS_W-1:0]  cap,
   input  logic [CNT_W-1:0] cnt,
   output logic             valid,
   output logic [TS_W-1:0]  o_stamp,
   output logic [CNT_W-1:0] o_count,
   output logic             o_none
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         o_stamp <= '0;
         o_count <= '0;
         o_none  <= 1'b0;
      end else begin
         valid <= take;
         if (take) begin
            o_stamp <= cap;
            o_count <= cnt;
            o_none  <= (cnt == '0);
         end
      end
   end
endmodule

// File: rtl/sample_edge_meter.sv
module sample_edge_meter #(
   parameter int unsigned TS_W           = 10,
   parameter int unsigned CNT_W          = 8,
   parameter int unsigned NOMINAL_PERIOD = 480,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             meas_in,
   input  logic             strobe_in,
   output logic             res_valid,
   output logic [TS_W-1:0]  res_stamp,
   output logic [CNT_W-1:0] res_count,
   output logic             res_none
);
   if (SYNC_STAGES < sem_pkg::MIN_SYNC_STAGES) begin : g_bad_sync
      $error("sample_edge_meter: SYNC_STAGES below minimum");
   end
   if (!sem_pkg::period_fits(NOMINAL_PERIOD, TS_W)) begin : g_bad_period
      $error("sample_edge_meter: NOMINAL_PERIOD does not fit TS_W");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("sample_edge_meter: CNT_W must be at least 1");
   end

   logic             meas_rise;
   logic             stb_rise;
   logic [TS_W-1:0]  stamp;
   logic [TS_W-1:0]  cap;
   logic [CNT_W-1:0] cnt;

   sem_sync_rise #(.STAGES(SYNC_STAGES)) u_meas_sync (
      .clk(clk), .rst_n(rst_n), .din(meas_in), .rise(meas_rise)
   );

   sem_sync_rise #(.STAGES(SYNC_STAGES)) u_stb_sync (
      .clk(clk), .rst_n(rst_n), .din(strobe_in), .rise(stb_rise)
   );

   sem_stamp #(.TS_W(TS_W)) u_stamp (
      .clk(clk), .rst_n(rst_n), .restart(stb_rise), .stamp(stamp)
   );

   sem_recorder #(.TS_W(TS_W), .CNT_W(CNT_W)) u_rec (
      .clk(clk), .rst_n(rst_n), .stamp(stamp), .hit(meas_rise),
      .close(stb_rise), .cap(cap), .cnt(cnt)
   );

   sem_snapshot #(.TS_W(TS_W), .CNT_W(CNT_W)) u_snap (
      .clk(clk), .rst_n(rst_n), .take(stb_rise), .cap(cap), .cnt(cnt),
      .valid(res_valid), .o_stamp(res_stamp), .o_count(res_count),
      .o_none(res_none)
   );
endmodule

// File: rtl/sem_checker.sv
module sem_checker #(
   parameter int unsigned TS_W  = 10,
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stb_rise,
   input logic             meas_rise,
   input logic [TS_W-1:0]  stamp,
   input logic [TS_W-1:0]  cap,
   input logic [CNT_W-1:0] cnt,
   input logic             res_valid,
   input logic [TS_W-1:0]  res_stamp,
   input logic [CNT_W-1:0] res_count,
   input logic             res_none
);
   // R4
   valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R4
   valid_from_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(stb_rise));

   // R4
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> ($stable(res_stamp) && $stable(res_count) && $stable(res_none)));

   // R8
   none_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_none == (res_count == '0)));

   // R7
   empty_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_count == '0) |-> (res_stamp == '0));

   // R2
   cap_behind_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap <= stamp);

   // R9
   cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stb_rise |=> (cnt >= $past(cnt)));

   // R5
   coincident_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_rise && meas_rise) |=> (cnt == CNT_W'(1) && cap == '0));
endmodule

bind sample_edge_meter sem_checker #(.TS_W(TS_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .stb_rise(stb_rise), .meas_rise(meas_rise),
   .stamp(stamp), .cap(cap), .cnt(cnt), .res_valid(res_valid),
   .res_stamp(res_stamp), .res_count(res_count), .res_none(res_none)
);

// File: tb/sample_edge_meter_tb.sv
module sample_edge_meter_tb;
   localparam int TS_W   = 6;
   localparam int CNT_W  = 3;
   localparam int TS_MAX = (1 << TS_W) - 1;
   localparam int CN_MAX = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             meas_in = 1'b0;
   logic             strobe_in = 1'b0;
   logic             res_valid;
   logic [TS_W-1:0]  res_stamp;
   logic [CNT_W-1:0] res_count;
   logic             res_none;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   int exp_stamp = 0;
   int exp_count = 0;
   int exp_none  = 1;

   sample_edge_meter #(.TS_W(TS_W), .CNT_W(CNT_W), .NOMINAL_PERIOD(40),
                       .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .meas_in(meas_in), .strobe_in(strobe_in),
      .res_valid(res_valid), .res_stamp(res_stamp), .res_count(res_count),
      .res_none(res_none)
   );

   always #10 clk = ~clk;

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 50000 && !done) begin
         failures = failures + 1;
         $display("FAIL R4 watchdog expired: actual=%0d cycles expected<=50000", cycles);
         summary();
      end
   end

   task automatic check(string req, string what, int got, int expv);
      checks = checks + 1;
      if (got != expv) begin
         failures = failures + 1;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, expv);
      end
   endtask

   // One strobe period: strobe driven at offset 0, measured pulses at set bits of mask.
   // The result of the previous period must appear at the observation after offset 2.
   task automatic do_period(int len, bit [127:0] mask, string req);
      int n = 0;
      int last = -1;
      bit spurious = 1'b0;
      for (int k = 0; k < len; k++) begin
         strobe_in = (k == 0);
         meas_in   = mask[k];
         @(negedge clk);
         if (k == 2) begin
            check("R4", "valid pulse", int'(res_valid), 1);
            check(req, "stamp", int'(res_stamp), exp_stamp);
            check(req, "count", int'(res_count), exp_count);
            check("R8", "none flag", int'(res_none), exp_none);
         end else if (res_valid) begin
            spurious = 1'b1;
         end
      end
      check("R4", "no extra valid", int'(spurious), 0);
      for (int k = 0; k < len; k++) begin
         if (mask[k]) begin
            n = n + 1;
            last = k;
         end
      end
      exp_count = (n > CN_MAX) ? CN_MAX : n;
      exp_none  = (n == 0) ? 1 : 0;
      if (last <= 0) exp_stamp = 0;
      else           exp_stamp = (last - 1 > TS_MAX) ? TS_MAX : last - 1;
   endtask

   initial begin
      bit [127:0] m;
      repeat (3) @(negedge clk);
      check("R11", "reset valid", int'(res_valid), 0);
      check("R11", "reset stamp", int'(res_stamp), 0);
      check("R11", "reset count", int'(res_count), 0);
      check("R11", "reset none", int'(res_none), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // First period reports the empty interval since reset (R7, R11)
      do_period(40, '0, "R7");

      // R1: single edge swept over every offset of the period
      for (int k = 1; k < 40; k++) begin
         m = '0;
         m[k] = 1'b1;
         do_period(40, m, "R1");
      end

      // R2/R3: two edges, the later one wins
      m = '0; m[3] = 1'b1; m[10] = 1'b1;
      do_period(40, m, "R1");
      // five edges per period, input faster than strobe
      m = '0; m[7] = 1'b1; m[15] = 1'b1; m[23] = 1'b1; m[31] = 1'b1; m[38] = 1'b1;
      do_period(40, m, "R2");
      // R6: edge one cycle after the boundary must not disturb the five-edge report
      m = '0; m[1] = 1'b1;
      do_period(40, m, "R3");
      m = '0; m[20] = 1'b1;
      do_period(40, m, "R6");
      // R5: edge coincident with the strobe lands in the new period
      m = '0; m[0] = 1'b1;
      do_period(40, m, "R1");
      do_period(40, '0, "R5");
      // R9: nineteen edges saturate the count
      m = '0;
      for (int k = 2; k < 40; k += 2) m[k] = 1'b1;
      do_period(40, m, "R7");
      // R7: empty period after a full one clears everything
      do_period(40, '0, "R9");
      // R10: long gap without strobe saturates the timestamp
      m = '0; m[90] = 1'b1;
      do_period(100, m, "R7");
      do_period(40, '0, "R10");
      // flush the last result
      do_period(8, '0, "R7");

      done = 1'b1;
      summary();
   end
endmodule